// File: doc/BRIEF.md
# Sixteen-Line Register-Mapped I/O Expander Core

This core gives a controller sixteen general-purpose pins behind a byte-wide register port. It takes an address, write data, a write strobe and a read strobe, and it returns read data. Each pin can be an input or an output. An output can be push-pull or open-drain, and its data can be inverted. The pull-up and pull-down enables go straight out to the pad cells. Pin levels are synchronised and then watched for edges. For each line an edge can be rising, falling, either or none. A detected edge on an unmasked line latches a source bit, and any latched source pulls the shared interrupt line low. The controller clears a source bit by writing a one to it.

Two more functions sit alongside the pin banks. A spare clock pin can be used as a plain output, set by writing special byte values to one register. A keyed sequence of two writes to one address returns every register to its power-on value.

Top module: `gpio_expander_core`

## Requirements
- R1: After reset, every line is an input and masked, with sense 00. Source, pull, open-drain and polarity are all 0, and the output latch is all ones. The clock register is 0x00, irq_n is high and pad_oe is 0.
- R2: A 16-bit bank uses two addresses. Lines 0–7 are at odd address A and lines 8–15 are at A-1. The A values are: pull-up 0x07, pull-down 0x09, open-drain 0x0B, polarity 0x0D, direction 0x0F, data 0x11, mask 0x13, source 0x19.
- R3: A direction bit of 1 makes the line an input with pad_oe low. A direction bit of 0 makes it an output, driving pad_out with the data bit XOR the polarity bit.
- R4: reg_rdata changes one cycle after reg_rd is sampled. Reading a data address returns the pad level after a two-flop synchroniser, XOR polarity. Reading any other mapped address returns the stored byte. Unmapped addresses read 0x00.
- R5: With the open-drain bit set, an output line is driven only when its value is 0. When its value is 1, the line is released (pad_oe low), and pad_out is never high on that line.
- R6: The polarity bit inverts both the driven output value and the data read back.
- R7: Each line has a 2-bit sense field: 00 none, 01 rising, 10 falling, 11 both. Line k sits at bits [2(k mod 4)+1 : 2(k mod 4)] of address 0x17 - k/4. Edges are taken on the synchronised raw pad level.
- R8: A line whose mask bit is 1 never sets its source bit.
- R9: Writing 1 to a source bit clears it, and writing 0 leaves it unchanged. If an edge sets a bit in the same cycle that a write clears it, the bit stays set.
- R10: irq_n is low exactly while any source bit is set. The source bit and irq_n are registered one cycle after the synchronised edge.
- R11: Writing 0x1F to the clock register at 0x1E drives aux_out high with aux_oe set. Writing 0x10 drives it low. Any other value releases the pin (aux_oe low).
- R12: Writing 0x12 and then 0x34 to address 0x7D restores every register to its R1 value. Writes to other addresses between the two do not break the sequence. Any other value written to 0x7D disarms it.
- R13: pad_pu and pad_pd follow the pull-up and pull-down banks bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, registered |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| pad_pu | output | 16 | Pull-up enables |
| pad_pd | output | 16 | Pull-down enables |
| aux_out | output | 1 | Spare clock pin output value |
| aux_oe | output | 1 | Spare clock pin output enable |
| irq_n | output | 1 | Active-low summary interrupt |

## Verification
The pins are driven in several ways:
- Single rising and falling transitions on lines whose sense fields hold each of the four codes. This separates the codes and shows whether the field for each line is decoded from the right byte and bit pair.
- The same toggles on masked lines, and on lines in the upper byte. These separate the mask from the sense decode and check the reversed byte order.
- A write-one-to-clear timed to land in the same cycle as a fresh edge. This tells whether setting a bit or clearing it wins.
- The reset key written plainly, interrupted by a wrong value, and split by an unrelated write. This separates a reset sequence that is armed from one that has been disarmed.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int NLINES = 16;
    localparam int SENSE_W = 2 * NLINES;

    localparam logic [7:0] A_PU_HI   = 8'h06;
    localparam logic [7:0] A_PU_LO   = 8'h07;
    localparam logic [7:0] A_PD_HI   = 8'h08;
    localparam logic [7:0] A_PD_LO   = 8'h09;
    localparam logic [7:0] A_OD_HI   = 8'h0A;
    localparam logic [7:0] A_OD_LO   = 8'h0B;
    localparam logic [7:0] A_POL_HI  = 8'h0C;
    localparam logic [7:0] A_POL_LO  = 8'h0D;
    localparam logic [7:0] A_DIR_HI  = 8'h0E;
    localparam logic [7:0] A_DIR_LO  = 8'h0F;
    localparam logic [7:0] A_DAT_HI  = 8'h10;
    localparam logic [7:0] A_DAT_LO  = 8'h11;
    localparam logic [7:0] A_MSK_HI  = 8'h12;
    localparam logic [7:0] A_MSK_LO  = 8'h13;
    localparam logic [7:0] A_SNS_3   = 8'h14;
    localparam logic [7:0] A_SNS_2   = 8'h15;
    localparam logic [7:0] A_SNS_1   = 8'h16;
    localparam logic [7:0] A_SNS_0   = 8'h17;
    localparam logic [7:0] A_SRC_HI  = 8'h18;
    localparam logic [7:0] A_SRC_LO  = 8'h19;
    localparam logic [7:0] A_CLK     = 8'h1E;
    localparam logic [7:0] A_MISC    = 8'h1F;
    localparam logic [7:0] A_KEY     = 8'h7D;

    localparam logic [7:0] KEY_FIRST  = 8'h12;
    localparam logic [7:0] KEY_SECOND = 8'h34;
    localparam logic [7:0] AUX_HIGH   = 8'h1F;
    localparam logic [7:0] AUX_LOW    = 8'h10;

    typedef struct packed {
        logic [NLINES-1:0]  pu;
        logic [NLINES-1:0]  pd;
        logic [NLINES-1:0]  od;
        logic [NLINES-1:0]  pol;
        logic [NLINES-1:0]  dir;
        logic [NLINES-1:0]  data;
        logic [NLINES-1:0]  mask;
        logic [SENSE_W-1:0] sense;
        logic [NLINES-1:0]  src;
        logic [7:0]         clk_cfg;
        logic [7:0]         misc;
        logic               armed;
        logic [7:0]         rdata;
    } regs_t;

    localparam regs_t REGS_RST = '{
        pu: '0, pd: '0, od: '0, pol: '0,
        dir: '1, data: '1, mask: '1,
        sense: '0, src: '0,
        clk_cfg: 8'h00, misc: 8'h00,
        armed: 1'b0, rdata: 8'h00
    };
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            st_d[s] = st_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/gpx_edge.sv
module gpx_edge #(
    parameter int N = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   lvl,
    input  logic [2*N-1:0] sense,
    input  logic [N-1:0]   mask,
    output logic [N-1:0]   hit
);
    logic [N-1:0] prev_d, prev_q;

    assign prev_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        logic rise, fall;
        assign rise   = lvl[i] & ~prev_q[i];
        assign fall   = ~lvl[i] & prev_q[i];
        assign hit[i] = ~mask[i] & ((sense[2*i] & rise) | (sense[2*i+1] & fall));
    end
endmodule

// File: rtl/gpio_expander_core.sv
module gpio_expander_core
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [7:0]        reg_rdata,
    input  logic [NLINES-1:0] pad_in,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe,
    output logic [NLINES-1:0] pad_pu,
    output logic [NLINES-1:0] pad_pd,
    output logic              aux_out,
    output logic              aux_oe,
    output logic              irq_n
);
    regs_t q, d;
    logic [NLINES-1:0] lvl, hit, clr, drive;
    logic              key_fire;
    logic [7:0]        rd_mux, keep_rd;

    gpx_sync #(.W(NLINES), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(lvl)
    );

    gpx_edge #(.N(NLINES)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .sense(q.sense),
        .mask(q.mask), .hit(hit)
    );

    always_comb begin
        logic [NLINES-1:0] pin_view;
        pin_view = lvl ^ q.pol;
        case (reg_addr)
            A_PU_HI:  rd_mux = q.pu[15:8];
            A_PU_LO:  rd_mux = q.pu[7:0];
            A_PD_HI:  rd_mux = q.pd[15:8];
            A_PD_LO:  rd_mux = q.pd[7:0];
            A_OD_HI:  rd_mux = q.od[15:8];
            A_OD_LO:  rd_mux = q.od[7:0];
            A_POL_HI: rd_mux = q.pol[15:8];
            A_POL_LO: rd_mux = q.pol[7:0];
            A_DIR_HI: rd_mux = q.dir[15:8];
            A_DIR_LO: rd_mux = q.dir[7:0];
            A_DAT_HI: rd_mux = pin_view[15:8];
            A_DAT_LO: rd_mux = pin_view[7:0];
            A_MSK_HI: rd_mux = q.mask[15:8];
            A_MSK_LO: rd_mux = q.mask[7:0];
            A_SNS_3:  rd_mux = q.sense[31:24];
            A_SNS_2:  rd_mux = q.sense[23:16];
            A_SNS_1:  rd_mux = q.sense[15:8];
            A_SNS_0:  rd_mux = q.sense[7:0];
            A_SRC_HI: rd_mux = q.src[15:8];
            A_SRC_LO: rd_mux = q.src[7:0];
            A_CLK:    rd_mux = q.clk_cfg;
            A_MISC:   rd_mux = q.misc;
            default:  rd_mux = 8'h00;
        endcase
    end

    always_comb begin
        d        = q;
        clr      = '0;
        key_fire = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                A_PU_HI:  d.pu[15:8]     = reg_wdata;
                A_PU_LO:  d.pu[7:0]      = reg_wdata;
                A_PD_HI:  d.pd[15:8]     = reg_wdata;
                A_PD_LO:  d.pd[7:0]      = reg_wdata;
                A_OD_HI:  d.od[15:8]     = reg_wdata;
                A_OD_LO:  d.od[7:0]      = reg_wdata;
                A_POL_HI: d.pol[15:8]    = reg_wdata;
                A_POL_LO: d.pol[7:0]     = reg_wdata;
                A_DIR_HI: d.dir[15:8]    = reg_wdata;
                A_DIR_LO: d.dir[7:0]     = reg_wdata;
                A_DAT_HI: d.data[15:8]   = reg_wdata;
                A_DAT_LO: d.data[7:0]    = reg_wdata;
                A_MSK_HI: d.mask[15:8]   = reg_wdata;
                A_MSK_LO: d.mask[7:0]    = reg_wdata;
                A_SNS_3:  d.sense[31:24] = reg_wdata;
                A_SNS_2:  d.sense[23:16] = reg_wdata;
                A_SNS_1:  d.sense[15:8]  = reg_wdata;
                A_SNS_0:  d.sense[7:0]   = reg_wdata;
                A_SRC_HI: clr[15:8]      = reg_wdata;
                A_SRC_LO: clr[7:0]       = reg_wdata;
                A_CLK:    d.clk_cfg      = reg_wdata;
                A_MISC:   d.misc         = reg_wdata;
                A_KEY: begin
                    key_fire = q.armed && (reg_wdata == KEY_SECOND);
                    d.armed  = (reg_wdata == KEY_FIRST);
                end
                default: ;
            endcase
        end
        // a fresh edge outranks a clear in the same cycle
        d.src = (q.src & ~clr) | hit;
        if (reg_rd) d.rdata = rd_mux;
        keep_rd = d.rdata;
        if (key_fire) begin
            d       = REGS_RST;
            d.rdata = keep_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    assign drive     = q.data ^ q.pol;
    assign pad_out   = drive & ~q.od;
    assign pad_oe    = ~q.dir & ~(q.od & drive);
    assign pad_pu    = q.pu;
    assign pad_pd    = q.pd;
    assign aux_oe    = (q.clk_cfg == AUX_HIGH) || (q.clk_cfg == AUX_LOW);
    assign aux_out   = (q.clk_cfg == AUX_HIGH);
    assign irq_n     = ~|q.src;
    assign reg_rdata = q.rdata;

    // R8: a newly set source bit must come from a line unmasked the cycle before
    p_masked_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.src & ~$past(q.src) & $past(q.mask)) == '0));

    // R9: a one written to the low source byte clears it unless an edge hit
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_SRC_LO) |=>
        ((q.src[7:0] & $past(reg_wdata) & ~$past(hit[7:0])) == 8'h00));

    // R10: the interrupt only falls after an edge hit
    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(|hit));

    // R11: the high code turns the spare pin into a driven high output
    p_aux_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CLK && reg_wdata == AUX_HIGH) |=> (aux_oe && aux_out));

    // R12: the completed key restores masks, directions and sources
    p_key_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_KEY && reg_wdata == KEY_SECOND && q.armed) |=>
        (q.mask == '1 && q.dir == '1 && q.src == '0 && pad_oe == '0));
endmodule

// File: tb/tb_gpio_expander_core.sv
module tb_gpio_expander_core;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h00, reg_wdata = 8'h00;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic [15:0] pad_in = 16'h0000;
    logic [15:0] pad_out, pad_oe, pad_pu, pad_pd;
    logic        aux_out, aux_oe, irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_expander_core dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .aux_out(aux_out),
        .aux_oe(aux_oe), .irq_n(irq_n)
    );

    // behavioural reference, one 16-bit word per bank
    logic [15:0] m_bank [0:7];   // 0 pu 1 pd 2 od 3 pol 4 dir 5 data 6 mask 7 src
    logic [31:0] m_sense;
    logic [7:0]  m_clk, m_misc, m_rdata;
    bit          m_arm;
    logic [15:0] m_pipe [$];
    logic [15:0] m_prev;

    function automatic void model_defaults();
        for (int b = 0; b < 8; b++) m_bank[b] = 16'h0000;
        m_bank[4] = 16'hFFFF; m_bank[5] = 16'hFFFF; m_bank[6] = 16'hFFFF;
        m_sense = 0; m_clk = 0; m_misc = 0; m_arm = 0;
    endfunction

    function automatic logic [15:0] m_level();
        return m_pipe[0];
    endfunction

    function automatic logic [7:0] model_read(logic [7:0] a);
        logic [15:0] v;
        if (a >= 8'h06 && a <= 8'h13 && a != 8'h10 && a != 8'h11) begin
            v = m_bank[(a - 8'h06) / 2];
            return a[0] ? v[7:0] : v[15:8];
        end
        if (a == 8'h10 || a == 8'h11) begin
            v = m_level() ^ m_bank[3];
            return a[0] ? v[7:0] : v[15:8];
        end
        if (a >= 8'h14 && a <= 8'h17) return m_sense[8*(8'h17 - a) +: 8];
        if (a == 8'h18) return m_bank[7][15:8];
        if (a == 8'h19) return m_bank[7][7:0];
        if (a == 8'h1E) return m_clk;
        if (a == 8'h1F) return m_misc;
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            model_defaults();
            m_rdata = 0;
            m_pipe = '{16'h0000, 16'h0000};
            m_prev = 0;
        end else begin
            logic [15:0] lv, hits, clrs;
            logic [7:0]  rnext;
            bit          fire;
            lv = m_level();
            hits = 0;
            for (int k = 0; k < 16; k++) begin
                bit up, dn;
                up = lv[k] && !m_prev[k];
                dn = !lv[k] && m_prev[k];
                if (!m_bank[6][k] && ((m_sense[2*k] && up) || (m_sense[2*k+1] && dn)))
                    hits[k] = 1'b1;
            end
            rnext = reg_rd ? model_read(reg_addr) : m_rdata;
            clrs = 0;
            fire = 0;
            if (reg_wr) begin
                if (reg_addr >= 8'h06 && reg_addr <= 8'h13) begin
                    if (reg_addr[0]) m_bank[(reg_addr - 8'h06) / 2][7:0]  = reg_wdata;
                    else             m_bank[(reg_addr - 8'h06) / 2][15:8] = reg_wdata;
                end else if (reg_addr >= 8'h14 && reg_addr <= 8'h17) begin
                    m_sense[8*(8'h17 - reg_addr) +: 8] = reg_wdata;
                end else if (reg_addr == 8'h18) clrs[15:8] = reg_wdata;
                else if (reg_addr == 8'h19) clrs[7:0] = reg_wdata;
                else if (reg_addr == 8'h1E) m_clk = reg_wdata;
                else if (reg_addr == 8'h1F) m_misc = reg_wdata;
                else if (reg_addr == 8'h7D) begin
                    fire = m_arm && reg_wdata == 8'h34;
                    m_arm = reg_wdata == 8'h12;
                end
            end
            m_bank[7] = (m_bank[7] & ~clrs) | hits;
            if (fire) model_defaults();
            m_rdata = rnext;
            m_prev = lv;
            void'(m_pipe.pop_front());
            m_pipe.push_back(pad_in);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [15:0] eo, ee;
            for (int k = 0; k < 16; k++) begin
                bit v;
                v = m_bank[5][k] ^ m_bank[3][k];
                ee[k] = !m_bank[4][k] && !(m_bank[2][k] && v);
                eo[k] = v && !m_bank[2][k];
            end
            chk("R3 pad_oe", pad_oe, ee);
            chk("R5 pad_out", pad_out, eo);
            chk("R10 irq_n", irq_n, m_bank[7] == 0);
            chk("R4 rdata", reg_rdata, m_rdata);
            chk("R13 pulls", {pad_pu, pad_pd}, {m_bank[0], m_bank[1]});
            chk("R11 aux", {aux_oe, aux_out}, {m_clk == 8'h1F || m_clk == 8'h10, m_clk == 8'h1F});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic pads(input logic [15:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 defaults
        chk("R1 irq_n", irq_n, 1'b1);
        chk("R1 pad_oe", pad_oe, 16'h0000);
        rd(8'h0F, 8'hFF, "R1 dir lo");
        rd(8'h12, 8'hFF, "R1 mask hi");
        rd(8'h17, 8'h00, "R1 sense");
        rd(8'h1E, 8'h00, "R1 clock reg");
        rd(8'h40, 8'h00, "R4 unmapped");

        // R2 R3 layout and direction
        wr(8'h0F, 8'h0F); wr(8'h11, 8'hA0);
        wr(8'h0E, 8'h7F); wr(8'h10, 8'h80);
        @(negedge clk);
        chk("R3 oe", pad_oe, 16'h80F0);
        chk("R2 out", pad_out & pad_oe, 16'h80A0);
        // R6 polarity
        wr(8'h0D, 8'h10);
        @(negedge clk);
        chk("R6 out", pad_out & 16'h00F0, 16'h00B0);
        // R5 open drain
        wr(8'h0B, 8'h20);
        @(negedge clk);
        chk("R5 oe", pad_oe, 16'h80D0);
        chk("R5 out", pad_out & 16'h00F0, 16'h0090);
        // R4 R6 readback
        pads(16'h1234);
        rd(8'h11, 8'h24, "R4 R6 data lo");
        rd(8'h10, 8'h12, "R4 data hi");
        rd(8'h0B, 8'h20, "R4 od readback");

        // R7 edges
        pads(16'h0000);
        wr(8'h17, 8'h39); wr(8'h13, 8'h00);
        pads(16'h0001);
        rd(8'h19, 8'h01, "R7 rise line0");
        chk("R10 irq low", irq_n, 1'b0);
        wr(8'h19, 8'h00);
        rd(8'h19, 8'h01, "R9 zero keeps");
        wr(8'h19, 8'h01);
        rd(8'h19, 8'h00, "R9 clear");
        chk("R10 irq high", irq_n, 1'b1);
        pads(16'h0003);
        rd(8'h19, 8'h00, "R7 line1 rise ignored");
        pads(16'h0001);
        rd(8'h19, 8'h02, "R7 line1 fall");
        wr(8'h19, 8'hFF);
        pads(16'h0005);
        rd(8'h19, 8'h04, "R7 line2 rise");
        wr(8'h19, 8'hFF);
        pads(16'h0001);
        rd(8'h19, 8'h04, "R7 line2 fall");
        wr(8'h19, 8'hFF);
        pads(16'h0009);
        pads(16'h0001);
        rd(8'h19, 8'h00, "R7 line3 none");
        // upper lines
        wr(8'h14, 8'h04); wr(8'h12, 8'hDF); wr(8'h15, 8'h01);
        pads(16'h2101);
        rd(8'h18, 8'h20, "R7 R2 line13");
        rd(8'h19, 8'h00, "R8 masked line8");
        wr(8'h18, 8'hFF);
        chk("R10 irq after clr", irq_n, 1'b1);

        // R9 set beats clear in the same cycle
        @(negedge clk); pad_in = 16'h2100;
        @(negedge clk); @(negedge clk);
        @(negedge clk); pad_in = 16'h2101;
        @(negedge clk); @(negedge clk);
        reg_addr = 8'h19; reg_wdata = 8'h01; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        rd(8'h19, 8'h01, "R9 set wins");
        wr(8'h19, 8'h01);

        // R11 spare pin
        wr(8'h1E, 8'h1F);
        chk("R11 high", {aux_oe, aux_out}, 2'b11);
        wr(8'h1E, 8'h10);
        chk("R11 low", {aux_oe, aux_out}, 2'b10);
        wr(8'h1E, 8'h00);
        chk("R11 release", aux_oe, 1'b0);

        // R13 pulls
        wr(8'h07, 8'h55); wr(8'h08, 8'hAA);
        chk("R13 pu", pad_pu, 16'h0055);
        chk("R13 pd", pad_pd, 16'hAA00);

        // R12 key
        wr(8'h7D, 8'h12); wr(8'h7D, 8'h00); wr(8'h7D, 8'h34);
        rd(8'h0F, 8'h0F, "R12 disarmed");
        wr(8'h1E, 8'h1F);
        wr(8'h7D, 8'h12); wr(8'h1F, 8'h5A); wr(8'h7D, 8'h34);
        rd(8'h0F, 8'hFF, "R12 dir restored");
        rd(8'h13, 8'hFF, "R12 mask restored");
        rd(8'h1F, 8'h00, "R12 misc restored");
        chk("R12 pad_oe", pad_oe, 16'h0000);
        chk("R12 aux", aux_oe, 1'b0);
        chk("R12 pulls", {pad_pu, pad_pd}, 32'h0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule